// File: doc/BRIEF.md
# LPM Sleep Tracker

This block follows a USB device through Link Power Management sleep. It does not decode tokens. An upstream decoder gives it a one-cycle pulse when the device has acknowledged an LPM request, and with that pulse the remote-wake bit carried in the extended token. After the acknowledge, the block opens a token-retry window measured in millisecond ticks. The device is reported as LPM-suspended only once that window has run out with no bus activity and no reset.

While the device is suspended, two things can end the sleep. The host can resume it, or software can issue a write-zero strobe. The software strobe wakes the device only if the host granted remote-wake permission in the token. When it does, the block emits a one-cycle remote-wakeup request that the line signalling logic acts on. A bus reset returns everything to the awake state. When the LPM-supported configuration input is low, the whole tracker holds its state.

The controller is a three-state machine:
- **ST_AWAKE**: normal operation.
- **ST_WINDOW**: the retry window is running.
- **ST_ASLEEP**: LPM-suspended.

Its transitions are:
- **ack**: ST_AWAKE to ST_WINDOW, on an accepted acknowledge.
- **expire**: ST_WINDOW to ST_ASLEEP, on the RETRY_MS-th tick.
- **abort**: ST_WINDOW to ST_AWAKE, on bus activity.
- **host_wake**: any state to ST_AWAKE, on a host resume or a bus reset.
- **remote_wake**: ST_ASLEEP to ST_AWAKE, on a permitted software strobe.

Top module: `lpm_sleep_tracker`

## Requirements
- R1: After an accepted acknowledge, `suspended` stays 0 until RETRY_MS cycles with `ms_tick`=1 have been seen in ST_WINDOW. It reads 1 in the cycle after the clock edge that samples the RETRY_MS-th tick. A tick in the acknowledge cycle itself does not count.
- R2: An acknowledge (`lpm_ack`=1) is accepted only in ST_AWAKE. On acceptance, `wake_permit` is loaded with `ack_wake` at the next edge.
- R3: `bus_reset`=1 with `lpm_en`=1 returns the block to ST_AWAKE at the next edge. It clears `wake_permit`, abandons any open window, and takes priority over every other input.
- R4: `host_resume`=1 with `lpm_en`=1 clears `suspended` and `wake_permit` at the next edge.
- R5: `sw_clear`=1 while suspended with `wake_permit`=1 gives `wakeup_req`=1 for exactly one cycle after the edge. At that same edge, `suspended` and `wake_permit` both go to 0.
- R6: `sw_clear` has no effect when `wake_permit`=0 or when the block is not suspended. In that case `wakeup_req` stays 0 and `suspended`/`wake_permit` keep their values.
- R7: `bus_activity`=1 in ST_WINDOW returns the block to ST_AWAKE without suspending. Later ticks do not suspend the device.
- R8: While `lpm_en`=0, `suspended`, `wake_permit` and the window tick count hold, and `wakeup_req` stays 0, whatever the other inputs do.
- R9: After reset, `suspended`, `wake_permit` and `wakeup_req` are 0.
- R10: `lpm_ack` in ST_WINDOW or ST_ASLEEP is ignored: the window does not restart and `wake_permit` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lpm_en | input | 1 | LPM supported; when 0 the tracker holds |
| lpm_ack | input | 1 | One-cycle pulse: LPM request acknowledged |
| ack_wake | input | 1 | Remote-wake bit from the extended token, valid with lpm_ack |
| host_resume | input | 1 | One-cycle pulse: host-initiated resume seen |
| bus_reset | input | 1 | One-cycle pulse: bus reset seen |
| bus_activity | input | 1 | Bus traffic observed (aborts the window) |
| sw_clear | input | 1 | Software write-zero strobe to the suspended status |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| suspended | output | 1 | LPM-suspended status |
| wake_permit | output | 1 | Remote wake permitted by host |
| wakeup_req | output | 1 | One-cycle remote-wakeup request |

## Verification
The bench builds the tracker with RETRY_MS set to 4, so that every path through the retry window needs only a few ticks. At that size the tests can cover the tick just before expiry, a window paused part-way by `lpm_en` and then completed, and aborts by activity and by reset inside the window. The default of 10 changes only the count limit, not the structure.

// File: rtl/lpm_trk_pkg.sv
package lpm_trk_pkg;
    typedef enum logic [1:0] {
        ST_AWAKE  = 2'd0,
        ST_WINDOW = 2'd1,
        ST_ASLEEP = 2'd2
    } lpm_state_e;
endpackage

// File: rtl/lpm_retry_timer.sv
// Counts millisecond ticks while the retry window runs.
module lpm_retry_timer #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && tick && (cnt_q == LAST);
endmodule

// File: rtl/lpm_wake_permit.sv
// Holds the host-granted remote-wake permission.
module lpm_wake_permit (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_val,
    input  logic clear,
    output logic permit
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            permit <= 1'b0;
        end else if (clear) begin
            permit <= 1'b0;
        end else if (load) begin
            permit <= load_val;
        end
    end
endmodule

// File: rtl/lpm_sleep_tracker.sv
module lpm_sleep_tracker
    import lpm_trk_pkg::*;
#(
    parameter int RETRY_MS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lpm_en,
    input  logic lpm_ack,
    input  logic ack_wake,
    input  logic host_resume,
    input  logic bus_reset,
    input  logic bus_activity,
    input  logic sw_clear,
    input  logic ms_tick,
    output logic suspended,
    output logic wake_permit,
    output logic wakeup_req
);
    lpm_state_e state_q, state_d;
    logic wake_d, wake_q;
    logic timer_clr, timer_run, window_done;
    logic host_wake;
    logic permit_load, permit_clear;

    assign host_wake = bus_reset || host_resume;

    // next-state logic
    always_comb begin
        state_d   = state_q;
        wake_d    = 1'b0;
        timer_clr = 1'b0;
        if (lpm_en) begin
            if (host_wake) begin
                state_d   = ST_AWAKE;
                timer_clr = 1'b1;
            end else begin
                unique case (state_q)
                    ST_AWAKE: begin
                        if (lpm_ack) begin
                            state_d   = ST_WINDOW;
                            timer_clr = 1'b1;
                        end
                    end
                    ST_WINDOW: begin
                        if (bus_activity) begin
                            state_d   = ST_AWAKE;
                            timer_clr = 1'b1;
                        end else if (window_done) begin
                            state_d = ST_ASLEEP;
                        end
                    end
                    ST_ASLEEP: begin
                        if (sw_clear && wake_permit) begin
                            state_d = ST_AWAKE;
                            wake_d  = 1'b1;
                        end
                    end
                    default: state_d = ST_AWAKE;
                endcase
            end
        end
    end

    assign timer_run    = lpm_en && (state_q == ST_WINDOW) && !host_wake && !bus_activity;
    assign permit_load  = lpm_en && (state_q == ST_AWAKE) && lpm_ack && !host_wake;
    assign permit_clear = lpm_en && (host_wake || wake_d);

    lpm_retry_timer #(.LIMIT(RETRY_MS)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (timer_clr),
        .run     (timer_run),
        .tick    (ms_tick),
        .expired (window_done)
    );

    lpm_wake_permit permit_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (permit_load),
        .load_val (ack_wake),
        .clear    (permit_clear),
        .permit   (wake_permit)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_AWAKE;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wake_q  <= wake_d;
        end
    end

    // outputs
    always_comb begin
        suspended  = (state_q == ST_ASLEEP);
        wakeup_req = wake_q;
    end
endmodule

// File: rtl/lpm_sleep_tracker_chk.sv
module lpm_sleep_tracker_chk
    import lpm_trk_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       lpm_en,
    input logic       lpm_ack,
    input logic       ack_wake,
    input logic       host_resume,
    input logic       bus_reset,
    input logic       bus_activity,
    input logic       sw_clear,
    input logic       ms_tick,
    input logic       suspended,
    input logic       wake_permit,
    input logic       wakeup_req,
    input lpm_state_e state
);
    // R1
    sleep_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspended) |-> $past(ms_tick) && $past(lpm_en));

    // R2
    permit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lpm_en && state == ST_AWAKE && lpm_ack && !bus_reset && !host_resume)
        |=> (wake_permit == $past(ack_wake)));

    // R3
    reset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lpm_en && bus_reset) |=> (!suspended && !wake_permit && state == ST_AWAKE));

    // R4
    resume_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lpm_en && host_resume) |=> (!suspended && !wake_permit));

    // R5
    wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wakeup_req |-> (!suspended && !wake_permit && $past(suspended) && $past(wake_permit)));

    // R5
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wakeup_req |=> !wakeup_req);

    // R6
    denied_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lpm_en && suspended && sw_clear && !wake_permit && !bus_reset && !host_resume)
        |=> (suspended && !wakeup_req));

    // R7
    activity_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lpm_en && state == ST_WINDOW && bus_activity && !bus_reset && !host_resume)
        |=> (!suspended && state == ST_AWAKE));

    // R8
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lpm_en |=> ($stable(suspended) && $stable(wake_permit) && !wakeup_req));
endmodule

bind lpm_sleep_tracker lpm_sleep_tracker_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .lpm_en       (lpm_en),
    .lpm_ack      (lpm_ack),
    .ack_wake     (ack_wake),
    .host_resume  (host_resume),
    .bus_reset    (bus_reset),
    .bus_activity (bus_activity),
    .sw_clear     (sw_clear),
    .ms_tick      (ms_tick),
    .suspended    (suspended),
    .wake_permit  (wake_permit),
    .wakeup_req   (wakeup_req),
    .state        (state_q)
);

// File: tb/lpm_sleep_tracker_tb_top.sv
module lpm_sleep_tracker_tb_top;
    localparam int RETRY = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lpm_en = 1'b1;
    logic lpm_ack = 1'b0, ack_wake = 1'b0, host_resume = 1'b0, bus_reset = 1'b0;
    logic bus_activity = 1'b0, sw_clear = 1'b0, ms_tick = 1'b0;
    logic suspended, wake_permit, wakeup_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    string phase = "R9";

    // behavioural reference: 0 awake, 1 counting, 2 asleep
    int m_mode = 0;
    int m_ticks = 0;
    bit m_perm = 1'b0;
    bit m_pulse = 1'b0;

    always #5 clk = ~clk;

    lpm_sleep_tracker #(.RETRY_MS(RETRY)) dut_i (
        .clk(clk), .rst_n(rst_n), .lpm_en(lpm_en), .lpm_ack(lpm_ack),
        .ack_wake(ack_wake), .host_resume(host_resume), .bus_reset(bus_reset),
        .bus_activity(bus_activity), .sw_clear(sw_clear), .ms_tick(ms_tick),
        .suspended(suspended), .wake_permit(wake_permit), .wakeup_req(wakeup_req)
    );

    always @(posedge clk) begin
        m_pulse = 1'b0;
        if (!rst_n) begin
            m_mode = 0; m_ticks = 0; m_perm = 1'b0;
        end else if (lpm_en) begin
            if (bus_reset || host_resume) begin
                m_mode = 0; m_perm = 1'b0;
            end else if (m_mode == 0 && lpm_ack) begin
                m_mode = 1; m_ticks = 0; m_perm = ack_wake;
            end else if (m_mode == 1) begin
                if (bus_activity) m_mode = 0;
                else if (ms_tick) begin
                    m_ticks++;
                    if (m_ticks >= RETRY) m_mode = 2;
                end
            end else if (m_mode == 2 && sw_clear && m_perm) begin
                m_mode = 0; m_perm = 1'b0; m_pulse = 1'b1;
            end
        end
    end

    task automatic check(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(phase, "model suspended", suspended, m_mode == 2);
            check(phase, "model wake_permit", wake_permit, m_perm);
            check(phase, "model wakeup_req", wakeup_req, m_pulse);
        end
    end

    task automatic step();
        @(negedge clk);
        lpm_ack = 1'b0; host_resume = 1'b0; bus_reset = 1'b0;
        bus_activity = 1'b0; sw_clear = 1'b0; ms_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1;
            step();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        check("R9", "reset suspended", suspended, 1'b0);
        check("R9", "reset wake_permit", wake_permit, 1'b0);
        check("R9", "reset wakeup_req", wakeup_req, 1'b0);

        phase = "R1";
        lpm_ack = 1'b1; ack_wake = 1'b1; ms_tick = 1'b1; step();
        check("R2", "permit loaded", wake_permit, 1'b1);
        ticks(RETRY - 1);
        check("R1", "one tick short", suspended, 1'b0);
        ticks(1);
        check("R1", "window expired", suspended, 1'b1);

        phase = "R5";
        sw_clear = 1'b1; step();
        check("R5", "wakeup pulse", wakeup_req, 1'b1);
        check("R5", "suspend cleared", suspended, 1'b0);
        check("R5", "permit cleared", wake_permit, 1'b0);
        step();
        check("R5", "pulse ends", wakeup_req, 1'b0);

        phase = "R6";
        lpm_ack = 1'b1; ack_wake = 1'b0; step();
        check("R2", "permit zero loaded", wake_permit, 1'b0);
        ticks(RETRY);
        sw_clear = 1'b1; step();
        check("R6", "denied clear keeps sleep", suspended, 1'b1);
        check("R6", "denied clear no pulse", wakeup_req, 1'b0);

        phase = "R10";
        lpm_ack = 1'b1; ack_wake = 1'b1; step();
        check("R10", "ack while asleep", wake_permit, 1'b0);
        phase = "R4";
        host_resume = 1'b1; step();
        check("R4", "resume wakes", suspended, 1'b0);

        phase = "R7";
        lpm_ack = 1'b1; ack_wake = 1'b1; step();
        ticks(2);
        lpm_ack = 1'b1; ack_wake = 1'b0; step();
        check("R10", "ack in window ignored", wake_permit, 1'b1);
        bus_activity = 1'b1; step();
        ticks(RETRY + 2);
        check("R7", "aborted window", suspended, 1'b0);
        phase = "R6";
        sw_clear = 1'b1; step();
        check("R6", "clear while awake no pulse", wakeup_req, 1'b0);
        check("R6", "clear while awake keeps permit", wake_permit, 1'b1);

        phase = "R3";
        bus_reset = 1'b1; step();
        check("R3", "reset clears permit", wake_permit, 1'b0);
        lpm_ack = 1'b1; ack_wake = 1'b1; step();
        ticks(2);
        bus_reset = 1'b1; lpm_ack = 1'b1; sw_clear = 1'b1; step();
        check("R3", "reset in window permit", wake_permit, 1'b0);
        ticks(RETRY + 1);
        check("R3", "reset in window no sleep", suspended, 1'b0);

        phase = "R8";
        lpm_ack = 1'b1; ack_wake = 1'b1; step();
        ticks(RETRY);
        lpm_en = 1'b0;
        host_resume = 1'b1; step();
        bus_reset = 1'b1; step();
        sw_clear = 1'b1; step();
        check("R8", "frozen suspended", suspended, 1'b1);
        check("R8", "frozen permit", wake_permit, 1'b1);
        check("R8", "frozen no pulse", wakeup_req, 1'b0);
        lpm_en = 1'b1;
        phase = "R4";
        host_resume = 1'b1; step();
        check("R4", "resume after freeze", suspended, 1'b0);
        check("R4", "resume clears permit", wake_permit, 1'b0);

        phase = "R8";
        lpm_ack = 1'b1; ack_wake = 1'b1; step();
        ticks(1);
        lpm_en = 1'b0;
        ticks(RETRY + 3);
        check("R8", "paused window", suspended, 1'b0);
        lpm_en = 1'b1;
        ticks(RETRY - 2);
        check("R8", "resumed count short", suspended, 1'b0);
        ticks(1);
        check("R1", "paused window completes", suspended, 1'b1);

        step();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule